// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Arbiter

This unit sits beside a small 8-bit core and decides which interrupt the core services next. It takes two kinds of source. Edge-type sources raise a latched pending flag on a one-cycle event pulse. Level-type sources have no flag and request only while their input is held high. Every source has its own enable bit. A single global enable bit, as it would sit in the core's status register, gates all of them.

Each cycle the unit takes the lowest-numbered enabled pending source. It then drives a one-cycle acknowledge together with that source's vector index. On the same edge it drops the global enable and clears the winner's flag if the winner is an edge source. The core reports three things: returns from a handler, retired main-program instructions, and software writes that set or clear the global enable or clear flags. From these the unit enforces the immediate-disable rule and the one-instruction gap after a return.

Top module: `irq_arbiter`

## Requirements
- R1: Out of reset, `gie`, `irq_ack`, `irq_vec` and every edge flag read 0, and no return gap is pending.
- R2: An acknowledge needs four things in the previous cycle: the source pending, its `src_en` bit at 1, `gie` at 1, and no gap pending. `irq_ack` is high for exactly one cycle per acceptance.
- R3: Source i has vector i+1, and vector 0 stays reserved for reset. Edge sources take positions 0..NE-1, so vector 1 is external request 0, and level sources follow. When several sources are eligible, the lowest vector wins.
- R4: The edge that raises `irq_ack` also drives `gie` to 0. A `reti` pulse sets `gie` to 1 on the next edge.
- R5: The edge that raises `irq_ack` clears the winning edge flag. A 1 in bit j of `flag_w1c` clears flag j. An event arriving in the same cycle as either clear leaves the flag set.
- R6: An edge flag that becomes set while its enable or `gie` is 0 stays set until it is served or cleared. Once enabled, pending flags are served one by one in vector order.
- R7: A level source has no flag. It is eligible only in cycles where `level_req` is high, and a request removed before it is enabled is never served.
- R8: A `reti` pulse arms a gap. No acceptance happens until an `insn_done` pulse has arrived in a later cycle. The earliest acknowledge comes on the edge after that `insn_done` cycle.
- R9: A `gie_clr` pulse blocks acceptance in its own cycle and leaves `gie` at 0, even when `gie_set` is high in the same cycle.
- R10: Setting `gie` inside a handler allows nesting: any enabled pending source is then accepted, whatever its vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| edge_evt | input | NE | One-cycle events that set the edge flags |
| level_req | input | NL | Held requests of the level sources |
| src_en | input | NE+NL | Per-source enables: edge sources in the low bits, level sources above |
| flag_w1c | input | NE | Write-one-to-clear strobes for the edge flags |
| gie_set | input | 1 | Software sets the global enable |
| gie_clr | input | 1 | Software clears the global enable (takes effect at once) |
| reti | input | 1 | Core returns from a handler |
| insn_done | input | 1 | Core retires one main-program instruction |
| irq_ack | output | 1 | One-cycle acceptance strobe |
| irq_vec | output | clog2(NE+NL+1) | Vector of the accepted source, valid with irq_ack |
| gie | output | 1 | Global enable state |
| edge_flags | output | NE | Pending edge flags |

## Verification
Directed sequences cover several distinct patterns, and each one separates a different kind of error:
- Flags latched with all enables off, then released together: shows whether order comes from vector position or from arrival.
- A disable and a set in the same cycle as a ready request: isolates the immediate-disable rule.
- A flag clear that coincides with a new event: exposes a reversed set/clear order.
- A level request that is dropped before it is enabled: separates flagless level sources from sources that are quietly latched.

A long seeded random run then mixes events, enable changes, returns and retire pulses. Every cycle it compares acknowledge, vector, global enable and flags against a cycle model written from the requirements.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  localparam int DEF_EDGE_SRCS  = 4;
  localparam int DEF_LEVEL_SRCS = 2;
endpackage

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int NE = 4,
  parameter int VW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] evt,
  input  logic [NE-1:0] w1c,
  input  logic          take,
  input  logic [VW-1:0] take_vec,
  output logic [NE-1:0] flags
);
  // one sticky bit per edge source; a new event outranks any clear
  for (genvar j = 0; j < NE; j++) begin : g_flag
    logic hit;
    logic f;
    assign hit = take && (take_vec == VW'(j + 1));
    always_ff @(posedge clk) begin
      if (rst)                  f <= 1'b0;
      else if (evt[j])          f <= 1'b1;
      else if (hit || w1c[j])   f <= 1'b0;
    end
    assign flags[j] = f;
  end
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NS = 6,
  parameter int VW = 3
) (
  input  logic [NS-1:0] pend,
  output logic          any,
  output logic [VW-1:0] vec
);
  // lowest position wins; vector = position + 1
  always_comb begin
    vec = '0;
    for (int i = NS - 1; i >= 0; i--) begin
      if (pend[i]) vec = VW'(i + 1);
    end
  end
  assign any = |pend;
endmodule

// File: rtl/irq_gate.sv
module irq_gate (
  input  logic clk,
  input  logic rst,
  input  logic any_pend,
  input  logic gie_set,
  input  logic gie_clr,
  input  logic reti,
  input  logic insn_done,
  output logic accept,
  output logic gie
);
  logic gap;

  assign accept = gie && !gie_clr && !gap && !reti && any_pend;

  always_ff @(posedge clk) begin
    if (rst) begin
      gie <= 1'b0;
      gap <= 1'b0;
    end else begin
      if (accept || gie_clr)    gie <= 1'b0;
      else if (gie_set || reti) gie <= 1'b1;
      if (reti)                 gap <= 1'b1;
      else if (insn_done)       gap <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_arbiter.sv
module irq_arbiter #(
  parameter  int NE = irq_arb_pkg::DEF_EDGE_SRCS,
  parameter  int NL = irq_arb_pkg::DEF_LEVEL_SRCS,
  localparam int NS = NE + NL,
  localparam int VW = $clog2(NS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [NE-1:0] edge_evt,
  input  logic [NL-1:0] level_req,
  input  logic [NS-1:0] src_en,
  input  logic [NE-1:0] flag_w1c,
  input  logic          gie_set,
  input  logic          gie_clr,
  input  logic          reti,
  input  logic          insn_done,
  output logic          irq_ack,
  output logic [VW-1:0] irq_vec,
  output logic          gie,
  output logic [NE-1:0] edge_flags
);
  logic [NS-1:0] pend;
  logic          any_pend;
  logic          accept;
  logic [VW-1:0] win_vec;

  assign pend = {level_req, edge_flags} & src_en;

  irq_flag_bank #(.NE(NE), .VW(VW)) u_flags (
    .clk(clk), .rst(rst), .evt(edge_evt), .w1c(flag_w1c),
    .take(accept), .take_vec(win_vec), .flags(edge_flags)
  );

  irq_prio_enc #(.NS(NS), .VW(VW)) u_prio (
    .pend(pend), .any(any_pend), .vec(win_vec)
  );

  irq_gate u_gate (
    .clk(clk), .rst(rst), .any_pend(any_pend), .gie_set(gie_set),
    .gie_clr(gie_clr), .reti(reti), .insn_done(insn_done),
    .accept(accept), .gie(gie)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_ack <= 1'b0;
      irq_vec <= '0;
    end else begin
      irq_ack <= accept;
      if (accept) irq_vec <= win_vec;
    end
  end
endmodule

// File: rtl/irq_arbiter_chk.sv
module irq_arbiter_chk #(
  parameter int NE = 4,
  parameter int NS = 6,
  parameter int VW = 3
) (
  input logic          clk,
  input logic          rst,
  input logic          irq_ack,
  input logic [VW-1:0] irq_vec,
  input logic          gie,
  input logic          reti,
  input logic          gie_clr,
  input logic [NE-1:0] edge_evt,
  input logic [NE-1:0] edge_flags
);
  p_ack_after_gie_r2: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> $past(gie));
  p_ack_one_cycle_r2: assert property (@(posedge clk) disable iff (rst)
    irq_ack |=> !irq_ack);
  p_vec_range_r3: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> (irq_vec != '0 && int'(irq_vec) <= NS));
  p_gie_drop_r4: assert property (@(posedge clk) disable iff (rst)
    irq_ack |-> !gie);
  p_reti_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (reti && !gie_clr) |=> gie);
  p_flag0_clear_r5: assert property (@(posedge clk) disable iff (rst)
    (irq_ack && irq_vec == VW'(1) && !$past(edge_evt[0])) |-> !edge_flags[0]);
  p_gap_r8: assert property (@(posedge clk) disable iff (rst)
    reti |=> !irq_ack);
  p_clr_now_r9: assert property (@(posedge clk) disable iff (rst)
    gie_clr |=> (!irq_ack && !gie));
endmodule

bind irq_arbiter irq_arbiter_chk #(.NE(NE), .NS(NS), .VW(VW)) u_chk (
  .clk(clk), .rst(rst), .irq_ack(irq_ack), .irq_vec(irq_vec), .gie(gie),
  .reti(reti), .gie_clr(gie_clr), .edge_evt(edge_evt), .edge_flags(edge_flags)
);

// File: tb/irq_arbiter_bench.sv
module irq_arbiter_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NE = 4;
  localparam int NL = 2;
  localparam int NS = NE + NL;
  localparam int VW = $clog2(NS + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [NE-1:0] edge_evt = '0;
  logic [NL-1:0] level_req = '0;
  logic [NS-1:0] src_en = '0;
  logic [NE-1:0] flag_w1c = '0;
  logic          gie_set = 1'b0, gie_clr = 1'b0, reti = 1'b0, insn_done = 1'b0;
  logic          irq_ack;
  logic [VW-1:0] irq_vec;
  logic          gie;
  logic [NE-1:0] edge_flags;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  // cycle model state, built from the requirements
  logic [NE-1:0] m_flags = '0;
  logic          m_gie = 1'b0, m_gap = 1'b0, m_ack = 1'b0;
  logic [VW-1:0] m_vec = '0;

  irq_arbiter #(.NE(NE), .NL(NL)) u_irq_arbiter (
    .clk(clk), .rst(rst), .edge_evt(edge_evt), .level_req(level_req),
    .src_en(src_en), .flag_w1c(flag_w1c), .gie_set(gie_set), .gie_clr(gie_clr),
    .reti(reti), .insn_done(insn_done), .irq_ack(irq_ack), .irq_vec(irq_vec),
    .gie(gie), .edge_flags(edge_flags)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [VW-1:0] best_vec(input logic [NS-1:0] p);
    logic [VW-1:0] v = '0;
    for (int i = NS - 1; i >= 0; i--) if (p[i]) v = VW'(i + 1);
    return v;
  endfunction

  task automatic tick();
    logic [NS-1:0] p;
    logic [VW-1:0] wv;
    logic acc;
    logic [NE-1:0] nf;
    p   = {level_req, m_flags} & src_en;
    wv  = best_vec(p);
    acc = !rst && m_gie && !gie_clr && !m_gap && !reti && (p != '0);
    for (int j = 0; j < NE; j++) begin
      if (edge_evt[j]) nf[j] = 1'b1;
      else if (flag_w1c[j] || (acc && wv == VW'(j + 1))) nf[j] = 1'b0;
      else nf[j] = m_flags[j];
    end
    @(posedge clk);
    #1;
    if (rst) begin
      m_flags = '0; m_gie = 1'b0; m_gap = 1'b0; m_ack = 1'b0; m_vec = '0;
    end else begin
      m_flags = nf;
      if (acc || gie_clr) m_gie = 1'b0;
      else if (gie_set || reti) m_gie = 1'b1;
      if (reti) m_gap = 1'b1;
      else if (insn_done) m_gap = 1'b0;
      m_ack = acc;
      if (acc) m_vec = wv;
    end
    chk(irq_ack === m_ack, "R2 model ack", int'(irq_ack), int'(m_ack));
    if (m_ack) chk(irq_vec === m_vec, "R3 model vector", int'(irq_vec), int'(m_vec));
    chk(gie === m_gie, "R4 model gie", int'(gie), int'(m_gie));
    chk(edge_flags === m_flags, "R5 model flags", int'(edge_flags), int'(m_flags));
  endtask

  task automatic step();
    tick();
    edge_evt = '0; flag_w1c = '0;
    gie_set = 1'b0; gie_clr = 1'b0; reti = 1'b0; insn_done = 1'b0;
  endtask

  task automatic leave_handler();
    reti = 1'b1; step();
    insn_done = 1'b1; step();
    step();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5A17));
    #(CLK_PERIOD / 4);
    rst = 1'b1;
    step(); step(); step();
    rst = 1'b0;
    step();
    chk(gie === 1'b0 && irq_ack === 1'b0, "R1 reset gie/ack", int'({gie, irq_ack}), 0);
    chk(edge_flags === '0 && irq_vec === '0, "R1 reset flags/vec", int'(edge_flags), 0);

    // latched while masked, then served in priority order
    edge_evt = 4'b1010; step();
    chk(edge_flags === 4'b1010, "R6 latch", int'(edge_flags), 10);
    step(); step(); step();
    chk(edge_flags === 4'b1010 && irq_ack === 1'b0, "R6 held", int'(edge_flags), 10);
    src_en = 6'b001111; gie_set = 1'b1; step();
    chk(gie === 1'b1 && irq_ack === 1'b0, "R4 set gie", int'(gie), 1);
    step();
    chk(irq_ack === 1'b1 && irq_vec === 3'd2, "R3 first winner", int'(irq_vec), 2);
    chk(gie === 1'b0, "R4 gie dropped on ack", int'(gie), 0);
    chk(edge_flags === 4'b1000, "R5 hw clear", int'(edge_flags), 8);
    step();
    chk(irq_ack === 1'b0, "R2 single pulse", int'(irq_ack), 0);
    reti = 1'b1; step();
    chk(gie === 1'b1 && irq_ack === 1'b0, "R4 reti sets gie", int'(gie), 1);
    step();
    chk(irq_ack === 1'b0, "R8 gap holds", int'(irq_ack), 0);
    insn_done = 1'b1; step();
    chk(irq_ack === 1'b0, "R8 retire cycle", int'(irq_ack), 0);
    step();
    chk(irq_ack === 1'b1 && irq_vec === 3'd4, "R8 R6 next in order", int'(irq_vec), 4);
    leave_handler();

    // immediate disable, software clears
    edge_evt = 4'b0001; step();
    gie_clr = 1'b1; gie_set = 1'b1; step();
    chk(irq_ack === 1'b0 && gie === 1'b0, "R9 disable same cycle", int'({irq_ack, gie}), 0);
    chk(edge_flags === 4'b0001, "R9 flag kept", int'(edge_flags), 1);
    flag_w1c = 4'b0001; step();
    chk(edge_flags === 4'b0000, "R5 w1c", int'(edge_flags), 0);
    edge_evt = 4'b0100; flag_w1c = 4'b0100; step();
    chk(edge_flags === 4'b0100, "R5 event beats clear", int'(edge_flags), 4);
    flag_w1c = 4'b0100; step();
    src_en = 6'b001101; edge_evt = 4'b0010; gie_set = 1'b1; step();
    step(); step();
    chk(irq_ack === 1'b0 && gie === 1'b1, "R2 source disabled", int'(irq_ack), 0);
    flag_w1c = 4'b0010; step();

    // level source
    src_en = 6'b001111; level_req = 2'b01; step(); step();
    level_req = 2'b00; step();
    src_en = 6'b111111; step(); step();
    chk(irq_ack === 1'b0, "R7 vanished request", int'(irq_ack), 0);
    level_req = 2'b01; step();
    chk(irq_ack === 1'b1 && irq_vec === 3'd5, "R7 level served", int'(irq_vec), 5);
    level_req = 2'b00;
    leave_handler();

    // nesting
    edge_evt = 4'b1000; step(); step();
    chk(irq_ack === 1'b1 && irq_vec === 3'd4, "R10 outer", int'(irq_vec), 4);
    level_req = 2'b10; step();
    chk(irq_ack === 1'b0, "R10 masked in handler", int'(irq_ack), 0);
    gie_set = 1'b1; step();
    step();
    chk(irq_ack === 1'b1 && irq_vec === 3'd6, "R10 nested", int'(irq_vec), 6);
    level_req = 2'b00;
    leave_handler();
    leave_handler();

    // seeded random traffic against the model
    for (int n = 0; n < 4000; n++) begin
      for (int j = 0; j < NE; j++) begin
        edge_evt[j] = ($urandom % 8) == 0;
        flag_w1c[j] = ($urandom % 16) == 0;
      end
      if (($urandom % 16) == 0) level_req = level_req ^ NL'($urandom);
      if (($urandom % 32) == 0) src_en = NS'($urandom);
      gie_set   = ($urandom % 8) == 0;
      gie_clr   = ($urandom % 16) == 0;
      reti      = ($urandom % 16) == 0;
      insn_done = ($urandom % 2) == 0;
      step();
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule